// File: doc/BRIEF.md
# Tagged Debug Channel FIFO Peripheral

This peripheral carries a byte-stream debug console, split into sixteen logical channels, between a CPU and an external debug host. Two shared FIFOs of 32-bit words, one for each direction, hold the traffic, and every stored word carries a 4-bit channel tag. On the CPU side there is a small word-aligned register window. A store to one of sixteen transmit slots queues the data word, and the slot index becomes the word's tag. A load from the receive slot returns the oldest received word and removes it. The status register shows the channel of that word before the load, so software knows in advance which channel it is about to read.

On the host side there is a simple stub. The host offers a tagged word to the receive FIFO with a valid/ready pair, and it takes tagged words from the transmit FIFO with a pop strobe. The peripheral reports occupancy counts and empty/full flags. It also drives a level interrupt, and software picks the condition that raises it for each direction with a 2-bit code in the configuration register.

Top module: `dbgch_periph`

## Requirements
- R1: The configuration register (offset 0x08) holds the TX interrupt code in bits [19:18] and the RX interrupt code in bits [17:16]. Both are writable. Bits [15:8] read the TX FIFO depth and bits [7:0] read the RX FIFO depth, and writes to these depth fields have no effect. All other bits read zero.
- R2: A write to offset 0x20 + 8·n (n = 0..15) queues the word with tag n. The host sees queued words in write order on host_tx_data/host_tx_chan, with host_tx_valid high while the FIFO is not empty.
- R3: A transmit write while the TX FIFO holds its full depth is discarded, and the stored words and the count stay unchanged.
- R4: host_rx_ready is high exactly when the RX FIFO is not full. A word offered while it is full is not stored.
- R5: The status register (offset 0x10) reads the TX count in [31:24] and the RX count in [23:16]. Bit 3 is RX empty, bit 2 is RX full, bit 1 is TX empty and bit 0 is TX full. All other bits not named in R6 read zero.
- R6: Status bits [7:4] hold the tag of the oldest RX word, or 0 when the RX FIFO is empty. After a receive read they show the tag of the next word.
- R7: A read of offset 0x18 returns the oldest RX word and removes it. A read while the RX FIFO is empty returns 0 and changes nothing.
- R8: TX interrupt codes are 0 off, 1 FIFO empty, 2 FIFO not full, and 3 near empty. Near empty means 4·count ≤ depth.
- R9: RX interrupt codes are 0 off, 1 FIFO full, 2 FIFO not empty, and 3 near full. Near full means 4·count ≥ 3·depth.
- R10: irq is the OR of the selected TX and RX conditions. It follows the FIFO state and the codes in the same cycle, with no extra register delay.
- R11: Reset empties both FIFOs and sets both interrupt codes to 0.
- R12: The access control register (offset 0x00) reads zero. Writes to 0x00, to the status or receive offsets, or to any unaligned address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_sel | input | 1 | CPU access strobe for this cycle |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte offset into the register window |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data (combinational) |
| host_rx_valid | input | 1 | Host offers a receive word |
| host_rx_chan | input | 4 | Tag of the offered word |
| host_rx_data | input | 32 | Offered data word |
| host_rx_ready | output | 1 | Receive FIFO can accept a word |
| host_tx_valid | output | 1 | Transmit FIFO holds a word |
| host_tx_chan | output | 4 | Tag of the oldest transmit word |
| host_tx_data | output | 32 | Oldest transmit word |
| host_tx_pop | input | 1 | Host removes the oldest transmit word |
| irq | output | 1 | Level interrupt |

## Verification
A pointer or count that falls out of step shows up as a status count that differs from the bench model on the next status read. It also shows up as a word or tag that comes out of order at the host port or at the receive register. Both are checked on every random step. A wrongly decoded slot shows up as the wrong tag when that word is popped. A wrong threshold comparison flips irq in the same cycle as the count change that triggers it, and the bench compares irq after every operation, with directed fills on both sides of each near-empty and near-full boundary.

// File: rtl/dbgch_pkg.sv
package dbgch_pkg;
    localparam int DATA_W   = 32;
    localparam int CHAN_W   = 4;
    localparam int NUM_CHAN = 16;

    localparam int IDX_CFG  = 1;   // word index of offset 0x08
    localparam int IDX_STAT = 2;   // 0x10
    localparam int IDX_RXD  = 3;   // 0x18
    localparam int IDX_TX0  = 4;   // 0x20, first transmit slot

    typedef struct packed {
        logic [CHAN_W-1:0] chan;
        logic [DATA_W-1:0] data;
    } tword_t;

    typedef enum logic [1:0] {
        TXT_OFF     = 2'd0,
        TXT_EMPTY   = 2'd1,
        TXT_NOTFULL = 2'd2,
        TXT_LOW     = 2'd3
    } tx_thr_e;

    typedef enum logic [1:0] {
        RXT_OFF      = 2'd0,
        RXT_FULL     = 2'd1,
        RXT_NOTEMPTY = 2'd2,
        RXT_HIGH     = 2'd3
    } rx_thr_e;

    function automatic logic tx_cond(tx_thr_e code, int cnt, int depth);
        case (code)
            TXT_EMPTY:   return cnt == 0;
            TXT_NOTFULL: return cnt < depth;
            TXT_LOW:     return (cnt * 4) <= depth;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic logic rx_cond(rx_thr_e code, int cnt, int depth);
        case (code)
            RXT_FULL:     return cnt == depth;
            RXT_NOTEMPTY: return cnt != 0;
            RXT_HIGH:     return (cnt * 4) >= (depth * 3);
            default:      return 1'b0;
        endcase
    endfunction
endpackage

// File: rtl/dbgch_fifo.sv
module dbgch_fifo
    import dbgch_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  tword_t                     pin,
    input  logic                       pop,
    output tword_t                     pout,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       empty,
    output logic                       full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    tword_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign pout    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= pin;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));
    a_r3_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == $past(count)));
    a_r7_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);
endmodule

// File: rtl/dbgch_irq.sv
module dbgch_irq
    import dbgch_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int TXC_W    = 4,
    parameter int RXC_W    = 4
) (
    input  tx_thr_e          tx_code,
    input  rx_thr_e          rx_code,
    input  logic [TXC_W-1:0] tx_count,
    input  logic [RXC_W-1:0] rx_count,
    output logic             irq
);
    logic tx_hit, rx_hit;

    always_comb begin
        tx_hit = tx_cond(tx_code, int'(tx_count), TX_DEPTH);
        rx_hit = rx_cond(rx_code, int'(rx_count), RX_DEPTH);
        irq    = tx_hit | rx_hit;
    end
endmodule

// File: rtl/dbgch_periph.sv
module dbgch_periph
    import dbgch_pkg::*;
#(
    parameter int TX_DEPTH = 8,
    parameter int RX_DEPTH = 8,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_sel,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [31:0]       cpu_wdata,
    output logic [31:0]       cpu_rdata,
    input  logic              host_rx_valid,
    input  logic [3:0]        host_rx_chan,
    input  logic [31:0]       host_rx_data,
    output logic              host_rx_ready,
    output logic              host_tx_valid,
    output logic [3:0]        host_tx_chan,
    output logic [31:0]       host_tx_data,
    input  logic              host_tx_pop,
    output logic              irq
);
    localparam int TXC_W = $clog2(TX_DEPTH + 1);
    localparam int RXC_W = $clog2(RX_DEPTH + 1);
    localparam int IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0] idx;
    logic             aligned, hit_cfg, hit_stat, hit_rxd, hit_tx;
    logic             wr_cyc, rd_cyc;
    logic [CHAN_W-1:0] slot;

    tx_thr_e tx_code;
    rx_thr_e rx_code;

    tword_t            tx_in, tx_head, rx_in, rx_head;
    logic [TXC_W-1:0]  tx_count;
    logic [RXC_W-1:0]  rx_count;
    logic              tx_empty, tx_full, rx_empty, rx_full;
    logic              tx_push, rx_pop;
    logic [31:0]       stat_word, cfg_word;

    // address decode: word index = byte offset / 8
    assign idx      = cpu_addr[ADDR_W-1:3];
    assign aligned  = (cpu_addr[2:0] == 3'b000);
    assign wr_cyc   = cpu_sel && cpu_wr;
    assign rd_cyc   = cpu_sel && !cpu_wr;
    assign hit_cfg  = aligned && (idx == IDX_W'(IDX_CFG));
    assign hit_stat = aligned && (idx == IDX_W'(IDX_STAT));
    assign hit_rxd  = aligned && (idx == IDX_W'(IDX_RXD));
    assign hit_tx   = aligned && (idx >= IDX_W'(IDX_TX0))
                              && (idx <  IDX_W'(IDX_TX0 + NUM_CHAN));
    assign slot     = CHAN_W'(idx - IDX_W'(IDX_TX0));

    // configuration: only the two threshold codes are state
    always_ff @(posedge clk) begin
        if (rst) begin
            tx_code <= TXT_OFF;
            rx_code <= RXT_OFF;
        end else if (wr_cyc && hit_cfg) begin
            tx_code <= tx_thr_e'(cpu_wdata[19:18]);
            rx_code <= rx_thr_e'(cpu_wdata[17:16]);
        end
    end

    assign tx_push    = wr_cyc && hit_tx;
    assign tx_in.chan = slot;
    assign tx_in.data = cpu_wdata;

    dbgch_fifo #(.DEPTH(TX_DEPTH)) u_txq (
        .clk(clk), .rst(rst),
        .push(tx_push), .pin(tx_in),
        .pop(host_tx_pop), .pout(tx_head),
        .count(tx_count), .empty(tx_empty), .full(tx_full)
    );

    assign rx_pop     = rd_cyc && hit_rxd;
    assign rx_in.chan = host_rx_chan;
    assign rx_in.data = host_rx_data;

    dbgch_fifo #(.DEPTH(RX_DEPTH)) u_rxq (
        .clk(clk), .rst(rst),
        .push(host_rx_valid), .pin(rx_in),
        .pop(rx_pop), .pout(rx_head),
        .count(rx_count), .empty(rx_empty), .full(rx_full)
    );

    assign host_rx_ready = !rx_full;
    assign host_tx_valid = !tx_empty;
    assign host_tx_chan  = tx_head.chan;
    assign host_tx_data  = tx_head.data;

    always_comb begin
        cfg_word        = '0;
        cfg_word[19:18] = tx_code;
        cfg_word[17:16] = rx_code;
        cfg_word[15:8]  = 8'(TX_DEPTH);
        cfg_word[7:0]   = 8'(RX_DEPTH);

        stat_word        = '0;
        stat_word[31:24] = 8'(tx_count);
        stat_word[23:16] = 8'(rx_count);
        stat_word[7:4]   = rx_head.chan;
        stat_word[3]     = rx_empty;
        stat_word[2]     = rx_full;
        stat_word[1]     = tx_empty;
        stat_word[0]     = tx_full;
    end

    always_comb begin
        cpu_rdata = '0;
        if (rd_cyc) begin
            if (hit_cfg)       cpu_rdata = cfg_word;
            else if (hit_stat) cpu_rdata = stat_word;
            else if (hit_rxd)  cpu_rdata = rx_head.data;
        end
    end

    dbgch_irq #(
        .TX_DEPTH(TX_DEPTH), .RX_DEPTH(RX_DEPTH),
        .TXC_W(TXC_W), .RXC_W(RXC_W)
    ) u_irq (
        .tx_code(tx_code), .rx_code(rx_code),
        .tx_count(tx_count), .rx_count(rx_count),
        .irq(irq)
    );

    a_r2_queue_visible: assert property (@(posedge clk) disable iff (rst)
        (tx_push && !tx_full && !host_tx_pop) |=> host_tx_valid);
    a_r4_rx_refuse: assert property (@(posedge clk) disable iff (rst)
        (!host_rx_ready && host_rx_valid && !rx_pop) |=> !host_rx_ready);
    a_r8_empty_irq: assert property (@(posedge clk) disable iff (rst)
        (tx_code == TXT_EMPTY && !host_tx_valid) |-> irq);
    a_r9_full_irq: assert property (@(posedge clk) disable iff (rst)
        (rx_code == RXT_FULL && !host_rx_ready) |-> irq);
    a_r10_quiet: assert property (@(posedge clk) disable iff (rst)
        (tx_code == TXT_OFF && rx_code == RXT_OFF) |-> !irq);
endmodule

// File: tb/dbgch_periph_bench.sv
`timescale 1ns/100ps
module dbgch_periph_bench;
    localparam int TXD = 8;
    localparam int RXD = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_sel = 0, cpu_wr = 0;
    logic [7:0]  cpu_addr = 0;
    logic [31:0] cpu_wdata = 0, cpu_rdata;
    logic        host_rx_valid = 0;
    logic [3:0]  host_rx_chan = 0;
    logic [31:0] host_rx_data = 0;
    logic        host_rx_ready, host_tx_valid, host_tx_pop = 0, irq;
    logic [3:0]  host_tx_chan;
    logic [31:0] host_tx_data;

    int n_chk = 0, n_fail = 0;
    logic [35:0] mtx[$];
    logic [35:0] mrx[$];
    int mtt = 0, mrt = 0;

    always #2.5 clk = ~clk;

    dbgch_periph #(.TX_DEPTH(TXD), .RX_DEPTH(RXD), .ADDR_W(8)) u_dbgch_periph (
        .clk(clk), .rst(rst), .cpu_sel(cpu_sel), .cpu_wr(cpu_wr),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
        .host_rx_valid(host_rx_valid), .host_rx_chan(host_rx_chan),
        .host_rx_data(host_rx_data), .host_rx_ready(host_rx_ready),
        .host_tx_valid(host_tx_valid), .host_tx_chan(host_tx_chan),
        .host_tx_data(host_tx_data), .host_tx_pop(host_tx_pop), .irq(irq)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_stat();
        logic [31:0] s = '0;
        s[31:24] = 8'(mtx.size());
        s[23:16] = 8'(mrx.size());
        s[7:4]   = (mrx.size() > 0) ? mrx[0][35:32] : 4'd0;
        s[3]     = (mrx.size() == 0);
        s[2]     = (mrx.size() == RXD);
        s[1]     = (mtx.size() == 0);
        s[0]     = (mtx.size() == TXD);
        return s;
    endfunction

    function automatic logic [31:0] exp_cfg();
        return {12'd0, 2'(mtt), 2'(mrt), 8'(TXD), 8'(RXD)};
    endfunction

    function automatic logic exp_irq();
        int t = mtx.size();
        int r = mrx.size();
        logic a, b;
        a = (mtt == 1) ? (t == 0) : (mtt == 2) ? (t < TXD) : (mtt == 3) ? (t * 4 <= TXD) : 1'b0;
        b = (mrt == 1) ? (r == RXD) : (mrt == 2) ? (r != 0) : (mrt == 3) ? (r * 4 >= RXD * 3) : 1'b0;
        return a | b;
    endfunction

    task automatic cpu_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_sel = 0; cpu_wr = 0;
    endtask

    task automatic cpu_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        cpu_sel = 1; cpu_wr = 0; cpu_addr = a;
        #1 d = cpu_rdata;
        @(negedge clk);
        cpu_sel = 0;
    endtask

    task automatic do_tx(input int ch, input logic [31:0] d);
        cpu_write(8'(32 + 8 * ch), d);
        if (mtx.size() < TXD) mtx.push_back({4'(ch), d});
    endtask

    task automatic do_cfg(input int tt, input int rt);
        cpu_write(8'h08, {12'd0, 2'(tt), 2'(rt), 16'hFFFF});
        mtt = tt; mrt = rt;
    endtask

    task automatic do_rxpush(input logic [3:0] ch, input logic [31:0] d);
        @(negedge clk);
        host_rx_valid = 1; host_rx_chan = ch; host_rx_data = d;
        #1 chk(host_rx_ready == (mrx.size() < RXD), "R4 ready", host_rx_ready, mrx.size() < RXD);
        @(negedge clk);
        host_rx_valid = 0;
        if (mrx.size() < RXD) mrx.push_back({ch, d});
    endtask

    task automatic do_txpop();
        logic [35:0] e;
        @(negedge clk);
        chk(host_tx_valid == (mtx.size() > 0), "R2 valid", host_tx_valid, mtx.size() > 0);
        if (mtx.size() > 0) begin
            e = mtx.pop_front();
            chk({host_tx_chan, host_tx_data} == e, "R2 word", {host_tx_chan, host_tx_data}, e);
        end
        host_tx_pop = 1;
        @(negedge clk);
        host_tx_pop = 0;
    endtask

    task automatic do_rxread();
        logic [31:0] d, e;
        e = (mrx.size() > 0) ? mrx[0][31:0] : 32'd0;
        cpu_read(8'h18, d);
        chk(d == e, "R7 rxdata", d, e);
        if (mrx.size() > 0) void'(mrx.pop_front());
    endtask

    task automatic chk_stat(input string tag);
        logic [31:0] d;
        cpu_read(8'h10, d);
        chk(d == exp_stat(), tag, d, exp_stat());
        chk(irq == exp_irq(), "R10 irq", irq, exp_irq());
    endtask

    task automatic chk_irq(input string tag);
        @(negedge clk);
        chk(irq == exp_irq(), tag, irq, exp_irq());
    endtask

    task automatic do_reset();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        mtx.delete(); mrx.delete(); mtt = 0; mrt = 0;
    endtask

    initial begin
        #900000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd1234));
        do_reset();

        // R11 reset state, R1 config layout, R12 access control
        chk_stat("R11 status after reset");
        cpu_read(8'h08, d); chk(d == exp_cfg(), "R11 cfg after reset", d, exp_cfg());
        cpu_read(8'h00, d); chk(d == 0, "R12 access reads zero", d, 0);
        chk(irq == 0, "R11 irq low", irq, 0);

        // R1 codes writable, depth fields read-only
        do_cfg(2, 1);
        cpu_read(8'h08, d); chk(d == exp_cfg(), "R1 cfg readback", d, exp_cfg());
        do_cfg(0, 0);

        // R7 read on empty gives 0 and leaves state
        do_rxread();
        chk_stat("R7 empty read no change");

        // R12 ignored writes
        cpu_write(8'h00, 32'hFFFF_FFFF);
        cpu_write(8'h10, 32'hFFFF_FFFF);
        cpu_write(8'h18, 32'hFFFF_FFFF);
        cpu_write(8'h24, 32'hDEAD_BEEF);
        chk_stat("R12 ignored writes");
        cpu_read(8'h00, d); chk(d == 0, "R12 access still zero", d, 0);

        // R3 fill past full, then drain in order, R2 tags per slot
        for (int i = 0; i < TXD + 3; i++) do_tx(15 - i, 32'hA000_0000 + i);
        chk_stat("R3 full status");
        chk(mtx.size() == TXD, "R3 model full", mtx.size(), TXD);
        for (int i = 0; i < TXD + 1; i++) do_txpop();
        chk_stat("R2 drained");

        // R8 near-empty boundary, R8 empty, not-full
        do_cfg(3, 0);
        chk_irq("R8 near empty at 0");
        do_tx(1, 1); do_tx(2, 2); chk_irq("R8 near empty at 2");
        do_tx(3, 3); chk_irq("R8 not near empty at 3");
        do_cfg(1, 0); chk_irq("R8 empty code, not empty");
        do_cfg(2, 0); chk_irq("R8 not full code");
        for (int i = 0; i < TXD; i++) do_tx(i, 32'h55 + i);
        chk_irq("R8 not full code at full");
        for (int i = 0; i < TXD; i++) do_txpop();
        do_cfg(1, 0); chk_irq("R8 empty code at empty");

        // R9 near-full boundary, R4 refuse, R6 head tag
        do_cfg(0, 3);
        for (int i = 0; i < 5; i++) do_rxpush(4'(i + 3), 32'hB000 + i);
        chk_irq("R9 not near full at 5");
        do_rxpush(4'd9, 32'hB005); chk_irq("R9 near full at 6");
        do_rxpush(4'd10, 1); do_rxpush(4'd11, 2);
        do_cfg(0, 1); chk_irq("R9 full code at full");
        do_rxpush(4'd12, 32'hBAD); chk_stat("R4 refused when full");
        chk_stat("R6 head tag");
        do_rxread(); chk_stat("R6 tag after pop");
        do_cfg(0, 2); chk_irq("R9 not empty code");
        while (mrx.size() > 0) do_rxread();
        chk_irq("R9 not empty code at empty");

        // R11 reset mid-run
        do_tx(5, 7); do_rxpush(4'd6, 8); do_cfg(3, 3);
        do_reset();
        chk_stat("R11 status after second reset");
        cpu_read(8'h08, d); chk(d == exp_cfg(), "R11 codes cleared", d, exp_cfg());

        // random mix, R5 status and R10 irq after each step
        for (int it = 0; it < 400; it++) begin
            case ($urandom_range(0, 5))
                0: do_tx($urandom_range(0, 15), $urandom);
                1: do_rxpush(4'($urandom_range(0, 15)), $urandom);
                2: do_txpop();
                3: do_rxread();
                4: do_cfg($urandom_range(0, 3), $urandom_range(0, 3));
                default: do_tx($urandom_range(0, 15), $urandom);
            endcase
            chk_stat("R5 random status");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule